// File: doc/BRIEF.md
# Write-Unlock Command Sequence Gate

This block sits in front of the write path of a byte-wide nonvolatile array and decides, write by write, whether a byte or page load may reach the array. It samples the chip-enable, output-enable and write-enable strobes together with the address and data buses on every clock. A write becomes an event on the clock where the write condition begins. Before any load is accepted, the block must see a fixed three-write key sequence. Each accepted key opens exactly one load, which may hold several bytes. The key writes themselves are consumed and never stored.

A write that arrives without a valid key is not simply dropped. That includes a key broken at any step. The write still opens a load period in which nothing commits. When the load period closes, the block launches the full busy period, exactly as a genuine load does. During that period reads act as status polls, and every write is ignored. The block drives a one-cycle commit-enable per accepted byte, a one-cycle busy-start pulse to the page sequencer and a busy level.

Top module: `ulk_write_gate`

## Requirements
- R1: A write event occurs on the first clock at which `ce_n`=0, `we_n`=0 and `oe_n`=1 are all sampled together. Holding `oe_n` low, `ce_n` high or `we_n` high produces no event, and such a cycle neither advances nor breaks the key sequence.
- R2: The key is three consecutive write events carrying address/data `0x1555/0xAA`, then `0x0AAA/0x55`, then `0x1555/0xA0` (parameter defaults, 13-bit address). Only after all three are seen may the following writes commit.
- R3: None of the three key writes raises `commit_en`.
- R4: `commit_en` is a one-cycle pulse in the cycle after the edge that sampled an accepted load write. It is never high while `busy` is high.
- R5: Consecutive writes of the key or of a load belong together only if the second write event comes at most `BLC_CYC` clocks after the first. A key interrupted by a longer gap is abandoned, and the next write is judged from the first key step.
- R6: A load ends `BLC_CYC` clocks after its last write event if no further write event arrives. At that edge `busy_start` pulses for one cycle and `busy` rises, and `busy` then stays high for exactly `WC_CYC` clocks.
- R7: A write that does not match the expected key step opens a rejected load. This covers a write with no key before it and a mismatch at the second or third step. Further writes in a rejected load also never commit, and the rejected load still ends in `busy_start` and a full busy period.
- R8: One key covers only the load that follows it. After the busy period ends, a write with no new key commits nothing.
- R9: Write events while `busy` is high have no effect. They do not commit, they do not advance the key, and they do not extend or restart the busy period.
- R10: During an open load, writes to the key addresses with key data are ordinary load bytes. They commit and do not restart the key.
- R11: If a complete key is followed by no write within `BLC_CYC` clocks, it lapses silently with no `busy_start` and no busy period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Sampled chip enable, active low |
| oe_n | input | 1 | Sampled output enable, active low |
| we_n | input | 1 | Sampled write enable, active low |
| addr | input | ADDR_W | Write address |
| data | input | DATA_W | Write data |
| commit_en | output | 1 | One-cycle pulse: the sampled write may be stored |
| busy_start | output | 1 | One-cycle pulse starting the internal write period |
| busy | output | 1 | High for the whole write period; reads are status polls |

## Verification
The hardest case to reach from the ports is a write landing on the exact edge where a window would otherwise run out. The gap must equal `BLC_CYC` clocks to be accepted, and one more clock must make the key lapse. The bench sets this up by placing idle cycles between its fixed two-cycle write strobes, so the gaps land on both sides of the limit. A second hard case is a key typed in full during a busy period. The bench provokes a rejected load, waits for `busy`, enters the key, and then shows that the write after the busy period still commits nothing while the busy length stays unchanged.

// File: rtl/ulk_gate_pkg.sv
package ulk_gate_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_STEP1   = 3'd1,
    ST_STEP2   = 3'd2,
    ST_ARMED   = 3'd3,
    ST_LOADING = 3'd4,
    ST_REJECT  = 3'd5,
    ST_BUSY    = 3'd6
  } gate_state_e;

  // States in which the inter-write window timer runs
  function automatic logic in_window(input gate_state_e s);
    return (s == ST_STEP1) || (s == ST_STEP2) || (s == ST_ARMED) ||
           (s == ST_LOADING) || (s == ST_REJECT);
  endfunction

  // States whose window expiry launches the busy period
  function automatic logic ends_in_busy(input gate_state_e s);
    return (s == ST_LOADING) || (s == ST_REJECT);
  endfunction

  // Key step index expected in a given state (0..2)
  function automatic logic [1:0] key_step(input gate_state_e s);
    case (s)
      ST_STEP1: return 2'd1;
      ST_STEP2: return 2'd2;
      default:  return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/ulk_strobe_detect.sv
module ulk_strobe_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic oe_n,
  input  logic we_n,
  output logic wr_evt
);
  logic wr_cond;
  logic wr_cond_q;

  assign wr_cond = !ce_n && !we_n && oe_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_cond_q <= 1'b0;
    else        wr_cond_q <= wr_cond;
  end

  assign wr_evt = wr_cond && !wr_cond_q;

  // R1: one strobe yields at most one event
  a_r1_single_event: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt |=> !wr_evt);

endmodule

// File: rtl/ulk_interval_timer.sv
module ulk_interval_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic expire
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;

  assign expire = run && !clear && (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (clear)            cnt <= '0;
    else if (run && !expire)   cnt <= cnt + 1'b1;
  end

  // R5/R6: counter never passes its limit
  a_r6_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(LIMIT));

endmodule

// File: rtl/ulk_write_gate.sv
module ulk_write_gate #(
  parameter int ADDR_W  = 13,
  parameter int DATA_W  = 8,
  parameter int BLC_CYC = 5000,
  parameter int WC_CYC  = 500000,
  parameter logic [ADDR_W-1:0] KEY_A0 = 13'h1555,
  parameter logic [DATA_W-1:0] KEY_D0 = 8'hAA,
  parameter logic [ADDR_W-1:0] KEY_A1 = 13'h0AAA,
  parameter logic [DATA_W-1:0] KEY_D1 = 8'h55,
  parameter logic [ADDR_W-1:0] KEY_A2 = 13'h1555,
  parameter logic [DATA_W-1:0] KEY_D2 = 8'hA0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output logic              commit_en,
  output logic              busy_start,
  output logic              busy
);
  import ulk_gate_pkg::*;

  gate_state_e state, state_d;
  logic wr_evt;
  logic step_ok;
  logic win_run, win_expire;
  logic bt_run, bt_expire;
  logic go_busy;
  logic commit_d;

  function automatic logic key_match(input logic [1:0] step,
                                     input logic [ADDR_W-1:0] a,
                                     input logic [DATA_W-1:0] d);
    case (step)
      2'd0:    return (a == KEY_A0) && (d == KEY_D0);
      2'd1:    return (a == KEY_A1) && (d == KEY_D1);
      default: return (a == KEY_A2) && (d == KEY_D2);
    endcase
  endfunction

  ulk_strobe_detect u_detect (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .wr_evt(wr_evt)
  );

  assign win_run = in_window(state);
  assign bt_run  = (state == ST_BUSY);

  ulk_interval_timer #(.LIMIT(BLC_CYC)) u_window (
    .clk(clk), .rst_n(rst_n), .clear(wr_evt), .run(win_run), .expire(win_expire)
  );

  ulk_interval_timer #(.LIMIT(WC_CYC)) u_busy (
    .clk(clk), .rst_n(rst_n), .clear(go_busy), .run(bt_run), .expire(bt_expire)
  );

  assign step_ok = key_match(key_step(state), addr, data);

  always_comb begin
    state_d  = state;
    go_busy  = 1'b0;
    commit_d = 1'b0;
    if (state == ST_BUSY) begin
      if (bt_expire) state_d = ST_IDLE;
    end else if (wr_evt) begin
      unique case (state)
        ST_IDLE:    state_d = step_ok ? ST_STEP1 : ST_REJECT;
        ST_STEP1:   state_d = step_ok ? ST_STEP2 : ST_REJECT;
        ST_STEP2:   state_d = step_ok ? ST_ARMED : ST_REJECT;
        ST_ARMED, ST_LOADING: begin
          state_d  = ST_LOADING;
          commit_d = 1'b1;
        end
        default:    state_d = ST_REJECT;
      endcase
    end else if (win_expire) begin
      if (ends_in_busy(state)) begin
        state_d = ST_BUSY;
        go_busy = 1'b1;
      end else begin
        state_d = ST_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      commit_en  <= 1'b0;
      busy_start <= 1'b0;
    end else begin
      state      <= state_d;
      commit_en  <= commit_d;
      busy_start <= go_busy;
    end
  end

  assign busy = (state == ST_BUSY);

  // R4: commits never overlap the write period
  a_r4_no_commit_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !commit_en);
  // R4: a commit answers a write event one cycle earlier
  a_r4_commit_after_event: assert property (@(posedge clk) disable iff (!rst_n)
    commit_en |-> $past(wr_evt));
  // R6: the busy level rises only together with its start pulse
  a_r6_busy_rise_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> busy_start);
  // R6: start pulse is accompanied by busy
  a_r6_start_with_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy_start |-> busy);
  // R9: no restart while already busy
  a_r9_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    busy_start |-> !$past(busy));
  // R6: busy launch comes from a quiet window, not from a write
  a_r6_start_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    busy_start |-> !$past(wr_evt));
  // R4: start and commit are never coincident
  a_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({commit_en, busy_start}));

endmodule

// File: tb/ulk_write_gate_bench.sv
`timescale 1ns/1ps
module ulk_write_gate_bench;
  localparam int AW  = 13;
  localparam int DW  = 8;
  localparam int BLC = 8;
  localparam int WC  = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] data = '0;
  logic commit_en, busy_start, busy;

  int checks = 0;
  int errors = 0;
  int bs_cnt = 0;
  int busy_len = 0;
  int cycles = 0;
  logic c;

  always #10 clk = ~clk;

  ulk_write_gate #(.ADDR_W(AW), .DATA_W(DW), .BLC_CYC(BLC), .WC_CYC(WC)) u_ulk_write_gate (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .data(data), .commit_en(commit_en),
    .busy_start(busy_start), .busy(busy)
  );

  always @(negedge clk) begin
    if (busy_start) bs_cnt++;
    if (busy) busy_len++;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic bit is_key0(input logic [AW-1:0] a, input logic [DW-1:0] d);
    return (a == 13'h1555) && (d == 8'hAA);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // raw strobe: two cycles, returns commit_en seen one cycle after the edge
  task automatic wr_raw(input logic cen, input logic oen,
                        input logic [AW-1:0] a, input logic [DW-1:0] d,
                        output logic cm);
    ce_n = cen; oe_n = oen; we_n = 1'b0; addr = a; data = d;
    @(negedge clk);
    cm = commit_en;
    ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, output logic cm);
    wr_raw(1'b0, 1'b1, a, d, cm);
  endtask

  task automatic key(input string req);
    logic k;
    wr(13'h1555, 8'hAA, k); chk({req, " key1 no commit (R3)"}, k, 0);
    wr(13'h0AAA, 8'h55, k); chk({req, " key2 no commit (R3)"}, k, 0);
    wr(13'h1555, 8'hA0, k); chk({req, " key3 no commit (R3)"}, k, 0);
  endtask

  task automatic clr_mon();
    bs_cnt = 0; busy_len = 0;
  endtask

  task automatic settle(input string req, input int exp_starts);
    idle(BLC + WC + 6);
    chk({req, " busy_start count"}, bs_cnt, exp_starts);
    chk({req, " busy length"}, busy_len, exp_starts * WC);
    clr_mon();
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // reset state
    chk("R4 reset commit_en", commit_en, 0);
    chk("R6 reset busy", busy, 0);
    chk("R6 reset busy_start", busy_start, 0);
    clr_mon();

    // R2/R3/R6: keyed page load of three bytes
    key("R2");
    wr(13'h0040, 8'h12, c); chk("R2 load byte 1 commits", c, 1);
    wr(13'h0041, 8'h34, c); chk("R2 load byte 2 commits", c, 1);
    idle(2);
    wr(13'h0042, 8'h56, c); chk("R2 load byte 3 commits", c, 1);
    settle("R6 keyed load", 1);

    // R8: the spent key does not cover the next write
    wr(13'h0050, 8'h77, c); chk("R8 write without new key", c, 0);
    settle("R7 unkeyed write", 1);

    // R7: mismatch at step 2
    wr(13'h1555, 8'hAA, c);
    wr(13'h0AAA, 8'h54, c); chk("R7 broken key step2", c, 0);
    wr(13'h0060, 8'h01, c); chk("R7 rejected load byte", c, 0);
    settle("R7 mismatch step2", 1);

    // R7: mismatch at step 3
    wr(13'h1555, 8'hAA, c);
    wr(13'h0AAA, 8'h55, c);
    wr(13'h1555, 8'hA1, c); chk("R7 broken key step3", c, 0);
    wr(13'h0061, 8'h02, c); chk("R7 rejected load after step3", c, 0);
    settle("R7 mismatch step3", 1);

    // R5: gap exactly BLC accepted
    wr(13'h1555, 8'hAA, c); idle(BLC - 2);
    wr(13'h0AAA, 8'h55, c); idle(BLC - 2);
    wr(13'h1555, 8'hA0, c); idle(BLC - 2);
    wr(13'h0070, 8'h99, c); chk("R5 gap at limit accepted", c, 1);
    settle("R5 limit load", 1);

    // R5: gap BLC+1 abandons key, next write judged as step one
    wr(13'h1555, 8'hAA, c); idle(BLC - 1);
    wr(13'h0AAA, 8'h55, c); chk("R5 lapsed key step2", c, 0);
    wr(13'h1555, 8'hA0, c);
    wr(13'h0071, 8'h98, c); chk("R5 lapsed key no commit", c, 0);
    settle("R5 lapsed key", 1);

    // R11: unused key lapses silently
    key("R11");
    settle("R11 key lapse", 0);

    // R1: inhibited strobes neither count nor break the key
    wr(13'h1555, 8'hAA, c);
    wr(13'h0AAA, 8'h55, c);
    wr_raw(1'b0, 1'b0, 13'h0000, 8'h00, c); // oe_n low
    wr_raw(1'b1, 1'b1, 13'h0000, 8'h00, c); // ce_n high
    wr(13'h1555, 8'hA0, c);
    wr(13'h0080, 8'h3C, c); chk("R1 inhibited strobes ignored", c, 1);
    settle("R1 load", 1);

    // R10: key addresses are ordinary bytes during a load
    key("R10");
    wr(13'h1555, 8'hAA, c); chk("R10 key address as data", c, 1);
    wr(13'h0AAA, 8'h55, c); chk("R10 second key address as data", c, 1);
    settle("R10 load", 1);

    // R9: key during busy has no effect
    wr(13'h0090, 8'h10, c);
    idle(BLC + 2);
    chk("R9 busy reached", busy, 1);
    wr(13'h1555, 8'hAA, c);
    wr(13'h0AAA, 8'h55, c);
    wr(13'h1555, 8'hA0, c);
    wr(13'h0091, 8'h11, c); chk("R9 write during busy", c, 0);
    settle("R9 not extended", 1);
    wr(13'h0092, 8'h12, c); chk("R9 key during busy not kept", c, 0);
    settle("R9 after busy", 1);

    // random mix
    for (int it = 0; it < 24; it++) begin
      int mode;
      int nb;
      logic [AW-1:0] ra;
      logic [DW-1:0] rd;
      mode = $urandom % 2;
      nb = 1 + ($urandom % 4);
      if (mode == 0) begin
        key("R2 rnd");
        for (int b = 0; b < nb; b++) begin
          ra = AW'($urandom); rd = DW'($urandom);
          wr(ra, rd, c); chk("R2 random keyed byte", c, 1);
          idle($urandom % (BLC - 1));
        end
      end else begin
        for (int b = 0; b < nb; b++) begin
          ra = AW'($urandom); rd = DW'($urandom);
          if (b == 0 && is_key0(ra, rd)) rd = 8'h00;
          wr(ra, rd, c); chk("R7 random unkeyed byte", c, 0);
          idle($urandom % (BLC - 1));
        end
      end
      settle("R6 random", 1);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1234));
  end

endmodule